// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block returns a next hop for a destination address using at most two table reads. The upper part of the address indexes a first table directly, with one entry for every possible value. An entry either gives the next hop or points to a small block in a second table. In the second case the low address bits select an entry inside that block. Control software expands every route into these two tables beforehand. Each entry therefore already holds the result of the most specific matching prefix, so the hardware needs no search.

Lookups are pipelined. One request is accepted every clock cycle, and each response arrives a fixed two cycles later, in the order the requests were made. A single write port loads entries into either table between lookups. A reserved next-hop value (all ones) marks an address that has no route.

Top module: `route_lookup_2lvl`

## Requirements
- R1: While reset is held and for the first two cycles after it, `rsp_valid` is low and `rsp_hop` holds the no-route code (all ones).
- R2: Every request sampled with `req_valid` high produces exactly one response. `rsp_valid` is high in the second cycle after the request and only then. Requests may arrive back to back, and responses keep their order.
- R3: A first-table entry is `{flag, payload}`, with the flag at bit HOP_W. When the entry indexed by `req_addr[ADDR_W-1:ADDR_W-L1_W]` has flag 0, the response is the payload (bits HOP_W-1:0).
- R4: When that entry has flag 1, its payload bits BLK_W-1:0 name a block. The response is the second-table entry at index `{block, req_addr[ADDR_W-L1_W-1:0]}`.
- R5: When the tables hold a correct expansion of a set of nested, overlapping prefixes, the response for every address is the next hop of the longest matching prefix.
- R6: An address that no prefix covers returns the no-route code (all ones). No separate miss port exists.
- R7: A write with `wr_l2` = 0 stores `wr_entry` at first-table index `wr_idx[L1_W-1:0]`. A write with `wr_l2` = 1 stores `wr_entry[HOP_W-1:0]` at second-table index `wr_idx[BLK_W+L2_W-1:0]` and ignores the flag bit. A lookup issued in the cycle after a write sees the new value, and a write to one table leaves the other unchanged.
- R8: `rsp_hop` keeps its value in cycles with no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Destination address to look up |
| wr_en | input | 1 | Table write strobe |
| wr_l2 | input | 1 | Write target: 0 = first table, 1 = second table |
| wr_idx | input | max(L1_W, BLK_W+L2_W) | Entry index for the write |
| wr_entry | input | HOP_W+1 | Entry value: flag at the top, payload below |
| rsp_valid | output | 1 | Response strobe |
| rsp_hop | output | HOP_W | Next hop, or all ones for no route |

## Verification
The tables are loaded with an expansion of nine nested prefixes whose lengths run from 1 to 16 bits. Every one of the 65536 addresses is then looked up back to back. Each response is compared against a longest-match computed directly from the prefix list. This sweep separates direct first-table hits, pointer-resolved addresses inside three expanded blocks, and uncovered addresses that must return the no-route code.

A second sequence spaces requests with idle cycles, which shows whether the response value holds between responses. Writes followed at once by lookups show whether an update is visible in the next cycle, whether the flag bit is dropped on second-table writes, and whether the other table is left untouched.

// File: rtl/route_lookup_2lvl.sv
module route_lookup_2lvl #(
  parameter int ADDR_W = 16,
  parameter int L1_W   = 12,
  parameter int HOP_W  = 8,
  parameter int BLK_W  = 4,
  parameter logic [HOP_W-1:0] NO_ROUTE = '1,
  localparam int L2_W   = ADDR_W - L1_W,
  localparam int L2_IW  = BLK_W + L2_W,
  localparam int WIDX_W = (L1_W > L2_IW) ? L1_W : L2_IW,
  localparam int ENT_W  = HOP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wr_en,
  input  logic              wr_l2,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0]  wr_entry,
  output logic              rsp_valid,
  output logic [HOP_W-1:0]  rsp_hop
);
  localparam int L1_N = 1 << L1_W;
  localparam int L2_N = 1 << L2_IW;

  logic [ENT_W-1:0] l1_mem [L1_N];
  logic [HOP_W-1:0] l2_mem [L2_N];

  logic             s1_valid;
  logic [ENT_W-1:0] s1_ent;
  logic [L2_W-1:0]  s1_lo;
  logic [HOP_W-1:0] s2_hop;
  logic             s2_valid;

  always_ff @(posedge clk)
    if (wr_en && !wr_l2) l1_mem[wr_idx[L1_W-1:0]] <= wr_entry;

  always_ff @(posedge clk)
    if (wr_en && wr_l2) l2_mem[wr_idx[L2_IW-1:0]] <= wr_entry[HOP_W-1:0];

  always_ff @(posedge clk)
    if (req_valid) begin
      s1_ent <= l1_mem[req_addr[ADDR_W-1:L2_W]];
      s1_lo  <= req_addr[L2_W-1:0];
    end

  wire [L2_IW-1:0] l2_idx  = {s1_ent[BLK_W-1:0], s1_lo};
  wire [HOP_W-1:0] hop_sel = s1_ent[HOP_W] ? l2_mem[l2_idx] : s1_ent[HOP_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s2_hop   <= NO_ROUTE;
    end else begin
      s1_valid <= req_valid;
      s2_valid <= s1_valid;
      if (s1_valid) s2_hop <= hop_sel;
    end

  assign rsp_valid = s2_valid;
  assign rsp_hop   = s2_hop;
endmodule

// File: rtl/route_lookup_2lvl_chk.sv
module route_lookup_2lvl_chk #(
  parameter int HOP_W = 8,
  parameter logic [HOP_W-1:0] NO_ROUTE = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic [HOP_W-1:0] rsp_hop,
  input logic             s1_valid,
  input logic [HOP_W:0]   s1_ent
);
  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= 2'd0;
    else if (since != 2'd2) since <= since + 2'd1;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    since != 2'd2 |-> !rsp_valid);

  a_r1_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
    since == 2'd0 |-> rsp_hop == NO_ROUTE);

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    since == 2'd2 |-> rsp_valid == $past(req_valid, 2));

  a_r3_direct_hop: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_ent[HOP_W] |=> rsp_hop == $past(s1_ent[HOP_W-1:0]));

  a_r8_hold_hop: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(rsp_hop));
endmodule

bind route_lookup_2lvl route_lookup_2lvl_chk #(.HOP_W(HOP_W), .NO_ROUTE(NO_ROUTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hop(rsp_hop), .s1_valid(s1_valid), .s1_ent(s1_ent)
);

// File: tb/tb_route_lookup_2lvl.sv
module tb_route_lookup_2lvl;
  localparam int NR = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        wr_en = 1'b0;
  logic        wr_l2 = 1'b0;
  logic [11:0] wr_idx = '0;
  logic [8:0]  wr_entry = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_hop;

  route_lookup_2lvl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .wr_en(wr_en), .wr_l2(wr_l2), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .rsp_valid(rsp_valid), .rsp_hop(rsp_hop)
  );

  always #4ns clk = ~clk;

  int r_pfx [NR] = '{16'h8000, 16'hA000, 16'hA500, 16'hA5C0, 16'hA5C8,
                     16'hA5CF, 16'h1230, 16'h3000, 16'h3FF0};
  int r_len [NR] = '{1, 4, 8, 12, 14, 16, 13, 4, 15};
  int r_hop [NR] = '{1, 2, 3, 4, 5, 6, 7, 8, 9};

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit hold_chk = 1'b0;
  logic [7:0] last_hop = 8'hFF;
  logic [7:0] exp_q[$];
  int         cyc_q[$];
  string      tag_q[$];
  int         ptr_123 = 0;

  function automatic logic [7:0] lpm(input logic [15:0] a);
    int best;
    logic [7:0] h;
    logic [15:0] m;
    best = -1;
    h = 8'hFF;
    for (int r = 0; r < NR; r++) begin
      m = (r_len[r] == 0) ? 16'h0 : (16'hFFFF << (16 - r_len[r]));
      if ((((a ^ r_pfx[r][15:0]) & m) == 16'h0) && r_len[r] > best) begin
        best = r_len[r];
        h = r_hop[r][7:0];
      end
    end
    return h;
  endfunction

  function automatic bit needs_blk(input logic [11:0] i);
    for (int r = 0; r < NR; r++)
      if (r_len[r] > 12 && r_pfx[r][15:4] == i) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (needs_blk(a[15:4])) return "R4 R5";
    if (lpm(a) == 8'hFF) return "R6";
    return "R3 R5";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input bit l2, input logic [11:0] idx, input logic [8:0] ent);
    wr_en = 1'b1; wr_l2 = l2; wr_idx = idx; wr_entry = ent;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [15:0] a, input logic [7:0] e, input string t);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(e); cyc_q.push_back(cyc); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        logic [7:0] e;
        int c;
        string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        check(cyc == c + 2, "R2", "response cycle", cyc, c + 2);
        check(rsp_hop == e, t, "next hop", rsp_hop, e);
      end
      last_hop = rsp_hop;
    end else if (hold_chk) begin
      check(rsp_hop == last_hop, "R8", "hop held while idle", rsp_hop, last_hop);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "valid in reset", rsp_valid, 0);
    check(rsp_hop == 8'hFF, "R1", "hop in reset", rsp_hop, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "valid after reset", rsp_valid, 0);
    check(rsp_hop == 8'hFF, "R1", "no-route code after reset", rsp_hop, 8'hFF);

    begin
      int nblk;
      nblk = 0;
      for (int i = 0; i < 4096; i++) begin
        if (needs_blk(12'(i))) begin
          if (i == 12'h123) ptr_123 = nblk;
          wr(1'b0, 12'(i), {1'b1, 8'(nblk)});
          for (int j = 0; j < 16; j++)
            wr(1'b1, {nblk[3:0], 4'(j)}, {1'b0, lpm({12'(i), 4'(j)})});
          nblk++;
        end else begin
          wr(1'b0, 12'(i), {1'b0, lpm({12'(i), 4'h0})});
        end
      end
    end

    for (int a = 0; a < 65536; a++) issue(16'(a), lpm(16'(a)), tag_of(16'(a)));
    repeat (3) @(negedge clk);

    hold_chk = 1'b1;
    for (int j = 0; j < 16; j++) begin
      issue({12'hA5C, 4'(j)}, lpm({12'hA5C, 4'(j)}), "R8 R4");
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    hold_chk = 1'b0;

    wr(1'b0, 12'h000, {1'b0, 8'h42});
    issue(16'h0005, 8'h42, "R7 first table");
    wr(1'b1, {4'(ptr_123), 4'h5}, {1'b1, 8'h5A});
    issue(16'h1235, 8'h5A, "R7 second table");
    issue(16'h0005, 8'h42, "R7 first table unchanged");
    issue(16'h1234, 8'h07, "R7 neighbour entry unchanged");
    wr(1'b0, 12'h123, {1'b0, 8'h33});
    issue(16'h1235, 8'h33, "R7 pointer replaced by hop");
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2", "outstanding requests", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule